// File: doc/BRIEF.md
# Multiplier-mode vertical pulse sequencer

This block drives one vertical transfer clock for a CCD timing generator. It runs on the pixel clock. A start strobe loads a register set and begins a sequence. The output first takes a programmed starting level. It then inverts at up to three programmed positions, and the sequence ends at a programmed end position. A busy flag is high while a sequence runs, and a one-cycle done strobe marks the end.

The block has two counting modes. In normal mode, positions are counted in single pixels. In multiplier mode, every position is a number of coarse units, and each unit lasts the programmed length in pixels. This lets a single pulse be many times wider than one line. An HD line-sync pulse restarts the counting when sweep is off. When sweep is on, HD is ignored, so a sequence can run across line boundaries.

Top module: `vpulse_seq`

## Requirements
- R1: One cycle after `start_i` is sampled high, `busy_o` is 1 and `vout_o` equals `cfg_start_pol`.
- R2: In normal mode (`cfg_mult_en`=0) the pixel count is 0 in the first cycle after start and rises by one each cycle. When the count equals a toggle register, `vout_o` is inverted in the next cycle. The first inverted cycle is therefore cycle T+1 after the start edge.
- R3: A toggle register holding 0 never inverts the output.
- R4: In multiplier mode (`cfg_mult_en`=1), a toggle with register value T inverts the output once T×L pixels have been counted, where L is `cfg_len`. The position grid therefore has a step of L pixels.
- R5: In multiplier mode, a `cfg_len` of 0 behaves exactly like a length of 1.
- R6: The end is reached when the count equals `cfg_rep`, or `cfg_rep`×L pixels in multiplier mode. In that cycle, toggles matching the end position still apply. In the next cycle `done_o` is 1 for exactly one cycle and `busy_o` is 0. After that, `vout_o` holds its level until the next start.
- R7: With `cfg_sweep_en`=0, an HD pulse during a sequence sets the count back to zero in the next cycle. This resets both the pixel and unit counts in multiplier mode. With `cfg_sweep_en`=1, HD has no effect.
- R8: All configuration inputs are captured on the start strobe. Changes made later do not affect the running sequence.
- R9: After reset, `vout_o`, `busy_o` and `done_o` are 0.
- R10: Every toggle register that matches the current position inverts the output. Two equal toggle registers therefore cancel each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hd_i | input | 1 | Line-sync pulse |
| start_i | input | 1 | Sequence start strobe; loads the configuration |
| cfg_start_pol | input | 1 | Starting output level |
| cfg_mult_en | input | 1 | 1 selects multiplier mode |
| cfg_sweep_en | input | 1 | 1 makes HD ignored during a sequence |
| cfg_tog1 | input | 12 | First toggle position |
| cfg_tog2 | input | 12 | Second toggle position |
| cfg_tog3 | input | 12 | Third toggle position |
| cfg_len | input | 10 | Unit length in pixels for multiplier mode |
| cfg_rep | input | 12 | End position |
| vout_o | output | 1 | Vertical transfer clock |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle end strobe |

## Verification
The assertions check the cycle-level handshake on every cycle:
- the starting level and busy flag after a start,
- done lasting one cycle and never coinciding with busy,
- busy dropping only with done,
- the output holding while idle.

Toggle placement cannot be shown by any single-cycle property. This covers the positions in both modes, the zero-length substitution, unused and cancelling toggles, HD restarts against sweep, and immunity to configuration changes mid-sequence. The bench scenarios show these by comparing the waveform with positions computed from the register values.

// File: rtl/vps_pkg.sv
// Shared widths and configuration record for the vertical pulse sequencer.
package vps_pkg;
    localparam int POS_W   = 12;
    localparam int LEN_W   = 10;
    localparam int NUM_TOG = 3;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        logic                          start_pol;
        logic                          mult_en;
        logic                          sweep_en;
        len_t                          len;
        pos_t                          rep;
        logic [NUM_TOG-1:0][POS_W-1:0] tog;
    } seq_cfg_t;
endpackage

// File: rtl/vps_cfg_capture.sv
// Configuration capture: on the start strobe, takes a snapshot of the
// register set. It also forms the effective unit length, which is never
// zero. Assumes load_i is a single-cycle strobe; values hold between loads.
module vps_cfg_capture
    import vps_pkg::*;
#(
    parameter int LEN_W_P = LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  seq_cfg_t          cfg_i,
    output seq_cfg_t          cfg_o,
    output logic [LEN_W_P-1:0] len_eff_o
);
    localparam logic [LEN_W_P-1:0] LEN_ONE = LEN_W_P'(1);

    seq_cfg_t              cfg_q;
    logic [LEN_W_P-1:0]    len_eff_q;

    // Snapshot the configuration and substitute 1 for a zero length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            len_eff_q <= LEN_ONE;
        end else if (load_i) begin
            cfg_q     <= cfg_i;
            len_eff_q <= (cfg_i.len == '0) ? LEN_ONE : LEN_W_P'(cfg_i.len);
        end
    end

    assign cfg_o     = cfg_q;
    assign len_eff_o = len_eff_q;
endmodule

// File: rtl/vps_pos_counter.sv
// Position counter. In normal mode, pos counts pixels. In multiplier mode,
// a sub-counter runs from 0 to len-1. Each wrap advances pos, so pos then
// counts units. phase_zero_o marks the first pixel of each unit; it is
// always 1 in normal mode. Assumes len_eff_i is non-zero.
module vps_pos_counter
    import vps_pkg::*;
#(
    parameter int POS_W_P = POS_W,
    parameter int LEN_W_P = LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               run_i,
    input  logic               mult_i,
    input  logic [LEN_W_P-1:0] len_eff_i,
    output logic [POS_W_P-1:0] pos_o,
    output logic               phase_zero_o
);
    logic [POS_W_P-1:0] pos_q;
    logic [LEN_W_P-1:0] sub_q;
    logic               sub_last;

    // Sub-counter wrap point for the current unit length.
    always_comb sub_last = (sub_q == (len_eff_i - LEN_W_P'(1)));

    // Advance the pixel/unit counters; a clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pos_q <= '0;
            sub_q <= '0;
        end else if (run_i) begin
            if (!mult_i) begin
                pos_q <= pos_q + POS_W_P'(1);
                sub_q <= '0;
            end else if (sub_last) begin
                pos_q <= pos_q + POS_W_P'(1);
                sub_q <= '0;
            end else begin
                sub_q <= sub_q + LEN_W_P'(1);
            end
        end
    end

    assign pos_o        = pos_q;
    assign phase_zero_o = (sub_q == '0);
endmodule

// File: rtl/vps_toggle_unit.sv
// Toggle and end detection. Each toggle register with a non-zero value
// that equals the current position inverts the output. Matches are
// combined by parity. The end is flagged when the position equals the end
// register. Evaluation happens only while fire_en_i is high.
module vps_toggle_unit #(
    parameter int NUM_TOG_P = vps_pkg::NUM_TOG,
    parameter int POS_W_P   = vps_pkg::POS_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic                              start_pol_i,
    input  logic                              fire_en_i,
    input  logic [POS_W_P-1:0]                pos_i,
    input  logic [NUM_TOG_P-1:0][POS_W_P-1:0] tog_i,
    input  logic [POS_W_P-1:0]                rep_i,
    output logic                              vout_o,
    output logic                              end_hit_o
);
    logic [NUM_TOG_P-1:0] hit;
    logic                 flip;
    logic                 vout_q;

    for (genvar gi = 0; gi < NUM_TOG_P; gi++) begin : g_match
        // One comparator per toggle register; zero means unused.
        always_comb hit[gi] = fire_en_i && (tog_i[gi] != '0) && (pos_i == tog_i[gi]);
    end

    // Net inversion from all matching registers.
    always_comb flip = ^hit;

    // Output level: load polarity on start, otherwise apply inversions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vout_q <= 1'b0;
        end else if (start_i) begin
            vout_q <= start_pol_i;
        end else if (flip) begin
            vout_q <= ~vout_q;
        end
    end

    assign vout_o    = vout_q;
    assign end_hit_o = fire_en_i && (pos_i == rep_i);
endmodule

// File: rtl/vpulse_seq.sv
// Top level of the vertical pulse sequencer. Captures the configuration on
// start and sequences one vertical clock output in normal or multiplier
// mode. It reports busy and a one-cycle done strobe. Assumes hd_i and
// start_i are synchronous to clk. A start during a running sequence
// restarts it.
module vpulse_seq
    import vps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hd_i,
    input  logic        start_i,
    input  logic        cfg_start_pol,
    input  logic        cfg_mult_en,
    input  logic        cfg_sweep_en,
    input  logic [11:0] cfg_tog1,
    input  logic [11:0] cfg_tog2,
    input  logic [11:0] cfg_tog3,
    input  logic [9:0]  cfg_len,
    input  logic [11:0] cfg_rep,
    output logic        vout_o,
    output logic        busy_o,
    output logic        done_o
);
    seq_cfg_t cfg_d;
    seq_cfg_t cfg_q;
    len_t     len_eff;
    pos_t     pos;
    logic     phase_zero;
    logic     fire_en;
    logic     end_hit;
    logic     hd_clear;
    logic     busy_q;
    logic     done_q;

    // Gather the register inputs into the configuration record.
    always_comb begin
        cfg_d           = '0;
        cfg_d.start_pol = cfg_start_pol;
        cfg_d.mult_en   = cfg_mult_en;
        cfg_d.sweep_en  = cfg_sweep_en;
        cfg_d.len       = cfg_len;
        cfg_d.rep       = cfg_rep;
        cfg_d.tog       = {cfg_tog3, cfg_tog2, cfg_tog1};
    end

    // HD restarts counting only while running with sweep off.
    always_comb hd_clear = busy_q && hd_i && !cfg_q.sweep_en;

    // Toggles and the end are evaluated on the first pixel of a unit.
    always_comb fire_en = busy_q && phase_zero;

    vps_cfg_capture #(.LEN_W_P(LEN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_i),
        .cfg_i     (cfg_d),
        .cfg_o     (cfg_q),
        .len_eff_o (len_eff)
    );

    vps_pos_counter #(.POS_W_P(POS_W), .LEN_W_P(LEN_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (start_i || hd_clear),
        .run_i        (busy_q),
        .mult_i       (cfg_q.mult_en),
        .len_eff_i    (len_eff),
        .pos_o        (pos),
        .phase_zero_o (phase_zero)
    );

    vps_toggle_unit #(.NUM_TOG_P(NUM_TOG), .POS_W_P(POS_W)) u_tog (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_pol_i (cfg_start_pol),
        .fire_en_i   (fire_en),
        .pos_i       (pos),
        .tog_i       (cfg_q.tog),
        .rep_i       (cfg_q.rep),
        .vout_o      (vout_o),
        .end_hit_o   (end_hit)
    );

    // Sequence control: start sets busy, the end drops it and pulses done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (end_hit) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
        end else begin
            done_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/vpulse_seq_chk.sv
// Protocol checker for vpulse_seq, attached with bind. It checks the start
// response, the done strobe shape and the output hold while idle.
module vpulse_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cfg_start_pol,
    input logic vout_o,
    input logic busy_o,
    input logic done_o
);
    logic past_ok;

    // Marks that at least one cycle out of reset has been observed.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_start_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && (vout_o == $past(cfg_start_pol))));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_busy_fall_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(busy_o)) |-> done_o);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !busy_o && !start_i) |=> $stable(vout_o));
endmodule

bind vpulse_seq vpulse_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .cfg_start_pol (cfg_start_pol),
    .vout_o        (vout_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
);

// File: tb/vpulse_seq_tb.sv
`timescale 1ns/1ps
module vpulse_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hd_i = 1'b0;
    logic        start_i = 1'b0;
    logic        cfg_start_pol = 1'b0;
    logic        cfg_mult_en = 1'b0;
    logic        cfg_sweep_en = 1'b0;
    logic [11:0] cfg_tog1 = '0;
    logic [11:0] cfg_tog2 = '0;
    logic [11:0] cfg_tog3 = '0;
    logic [9:0]  cfg_len = '0;
    logic [11:0] cfg_rep = '0;
    logic        vout_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vpulse_seq u_dut (.*);

    typedef struct packed {
        logic        pol;
        logic        mult;
        logic [11:0] t1;
        logic [11:0] t2;
        logic [11:0] t3;
        logic [9:0]  len;
        logic [11:0] rep;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 12'd3, 12'd10, 12'd0, 10'd0, 12'd12, 8'd3}, // R3 with R2
        '{1'b1, 1'b0, 12'd2, 12'd7,  12'd9, 10'd0, 12'd9,  8'd2}, // R2
        '{1'b0, 1'b1, 12'd2, 12'd9,  12'd0, 10'd4, 12'd9,  8'd4}, // R4 (8 and 36)
        '{1'b1, 1'b1, 12'd1, 12'd3,  12'd5, 10'd3, 12'd5,  8'd4}, // R4
        '{1'b0, 1'b1, 12'd3, 12'd0,  12'd0, 10'd0, 12'd5,  8'd5}, // R5
        '{1'b0, 1'b0, 12'd5, 12'd5,  12'd8, 10'd0, 12'd10, 8'd10}, // R10
        '{1'b1, 1'b0, 12'd0, 12'd0,  12'd0, 10'd0, 12'd0,  8'd6}  // R6 immediate end
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic start_seq();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(input logic pol, input logic mult, input logic sweep,
                           input int t1, input int t2, input int t3,
                           input int len, input int rep);
        cfg_start_pol = pol;
        cfg_mult_en   = mult;
        cfg_sweep_en  = sweep;
        cfg_tog1      = 12'(t1);
        cfg_tog2      = 12'(t2);
        cfg_tog3      = 12'(t3);
        cfg_len       = 10'(len);
        cfg_rep       = 12'(rep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        // R9: outputs after reset
        chk("R9 vout", int'(vout_o), 0);
        chk("R9 busy", int'(busy_o), 0);
        chk("R9 done", int'(done_o), 0);
        rst_n = 1'b1;
        step(2);

        // Table walk: the waveform is computed from positions times unit length.
        for (int v = 0; v < NV; v++) begin
            int l;
            int fin;
            string tag;
            l   = VECS[v].mult ? ((VECS[v].len == 0) ? 1 : int'(VECS[v].len)) : 1;
            fin = int'(VECS[v].rep) * l;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            set_cfg(VECS[v].pol, VECS[v].mult, 1'b0, int'(VECS[v].t1), int'(VECS[v].t2),
                    int'(VECS[v].t3), int'(VECS[v].len), int'(VECS[v].rep));
            start_seq();
            for (int k = 0; k <= fin + 3; k++) begin
                int kk;
                logic e;
                kk = (k < fin + 1) ? k : fin + 1;
                e  = VECS[v].pol;
                if (VECS[v].t1 != 0 && int'(VECS[v].t1) * l < kk) e = ~e;
                if (VECS[v].t2 != 0 && int'(VECS[v].t2) * l < kk) e = ~e;
                if (VECS[v].t3 != 0 && int'(VECS[v].t3) * l < kk) e = ~e;
                chk({tag, " vout"}, int'(vout_o), int'(e));
                chk({tag, " busy R6"}, int'(busy_o), int'(k <= fin));
                chk({tag, " done R6"}, int'(done_o), int'(k == fin + 1));
                if (k == 0) chk("R1 start level", int'(vout_o), int'(VECS[v].pol));
                step(1);
            end
        end

        // R7: HD with sweep off restarts the pixel count (flip moves from k=6 to k=10).
        set_cfg(1'b0, 1'b0, 1'b0, 5, 0, 0, 0, 20);
        start_seq();
        step(3);
        hd_i = 1'b1;
        step(1);
        hd_i = 1'b0;
        step(5);
        chk("R7 hd restart k9", int'(vout_o), 0);
        step(1);
        chk("R7 hd restart k10", int'(vout_o), 1);
        step(15);

        // R7: HD with sweep on is ignored (flip stays at k=6).
        set_cfg(1'b0, 1'b0, 1'b1, 5, 0, 0, 0, 20);
        start_seq();
        step(3);
        hd_i = 1'b1;
        step(1);
        hd_i = 1'b0;
        step(1);
        chk("R7 sweep k5", int'(vout_o), 0);
        step(1);
        chk("R7 sweep k6", int'(vout_o), 1);
        step(20);

        // R7: multiplier mode, HD at k=5 clears unit and sub counts (flip at k=15).
        set_cfg(1'b0, 1'b1, 1'b0, 2, 0, 0, 4, 9);
        start_seq();
        step(5);
        hd_i = 1'b1;
        step(1);
        hd_i = 1'b0;
        step(8);
        chk("R7 mult hd k14", int'(vout_o), 0);
        step(1);
        chk("R7 mult hd k15", int'(vout_o), 1);
        step(40);

        // R8: configuration changes after start do not alter the running sequence.
        set_cfg(1'b0, 1'b0, 1'b0, 4, 0, 0, 0, 10);
        start_seq();
        set_cfg(1'b1, 1'b1, 1'b0, 2, 1, 0, 7, 3);
        step(3);
        chk("R8 no early flip k3", int'(vout_o), 0);
        step(2);
        chk("R8 flip at k5", int'(vout_o), 1);
        step(5);
        chk("R8 still busy k10", int'(busy_o), 1);
        step(1);
        chk("R8 done k11", int'(done_o), 1);
        step(3);

        // R6: output held after the end while inputs move.
        set_cfg(1'b0, 1'b0, 1'b0, 3, 0, 0, 0, 4);
        hd_i = 1'b1;
        step(3);
        hd_i = 1'b0;
        chk("R6 hold after end", int'(vout_o), 1);

        // R9: reset in mid-sequence clears the outputs.
        set_cfg(1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 50);
        start_seq();
        step(2);
        rst_n = 1'b0;
        step(1);
        chk("R9 mid reset vout", int'(vout_o), 0);
        chk("R9 mid reset busy", int'(busy_o), 0);
        rst_n = 1'b1;
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule